// File: doc/BRIEF.md
# Ripple-Cascaded Four-Bit ALU Slice

The block is a purely combinational arithmetic/logic unit built from identical four-bit slices. Each slice takes two operands, a three-bit operation code and a carry input. It returns a result nibble, a carry output and a two's-complement overflow flag. The operation code alone selects among eight operations:

- two constant outputs (all zeros and all ones);
- two subtraction directions;
- addition;
- three bitwise logic functions.

Operands and results use active-HIGH levels only.

Subtraction adds the inverted subtrahend without the +1. The user supplies that +1 by driving the carry input of the least significant slice high. The top module chains `SLICES` slices. Each slice's carry output feeds the carry input of the next, more significant slice. The word's carry and overflow are taken from the most significant slice. With the default parameters the result is a 16-bit ALU.

Top module: `alu_ripple_word`

## Requirements
- R1: Operation code 3'b000 drives the result to all zeros, and carry out and overflow to 0.
- R2: Operation code 3'b111 drives the result to all ones, and carry out and overflow to 0.
- R3: Operation code 3'b011 gives {carry out, result} = A + B + carry in.
- R4: Operation code 3'b010 gives {carry out, result} = A + ~B + carry in, so carry in = 1 gives the two's-complement difference A - B.
- R5: Operation code 3'b001 gives {carry out, result} = B + ~A + carry in, so carry in = 1 gives B - A.
- R6: Operation codes 3'b100, 3'b101 and 3'b110 give bitwise A XOR B, A OR B and A AND B respectively.
- R7: In the constant and logic codes (000, 100, 101, 110, 111), carry out and overflow are 0 and the carry input has no effect on any output.
- R8: In the arithmetic codes (001, 010, 011), overflow is the XOR of the carry into the top bit and the carry out. It is 1 exactly when the two added operands share a sign and the result's sign differs.
- R9: The word-level module ripples carry through its slices: for every code its result, carry out and overflow equal those of a single slice of the full word width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | SLICES*4 | Operand A |
| b | input | SLICES*4 | Operand B |
| op | input | 3 | Operation code |
| cin | input | 1 | Carry into the least significant slice |
| f | output | SLICES*4 | Result word |
| cout | output | 1 | Carry out of the most significant slice |
| ovf | output | 1 | Two's-complement overflow of the most significant slice |

## Verification
The immediate assertions take for granted that the operands, code and carry are settled binary values. They are evaluated after the combinational logic has settled. The bench changes inputs only on the rising clock edge and compares only on the falling edge, so every comparison sees settled values. A single slice is driven through every combination of code, operands and carry. The full word gets directed corner values plus seeded random vectors, with carry in drawn from both values so that the case R7 forbids to matter is also applied.

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  input  logic             cin,
  output logic [WIDTH-1:0] f,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  typedef enum logic [2:0] {
    OP_ZERO = 3'b000, OP_SUB_BA = 3'b001, OP_SUB_AB = 3'b010, OP_ADD = 3'b011,
    OP_XOR  = 3'b100, OP_OR     = 3'b101, OP_AND    = 3'b110, OP_ONES = 3'b111
  } op_e;

  logic [WIDTH-1:0] opx, opy;
  logic [MSB-1:0]   low_sum;
  logic             c_msb;
  logic [1:0]       top_sum;
  logic             arith;

  always_comb begin
    unique case (op_e'(op))
      OP_SUB_BA: begin opx = b; opy = ~a; end
      OP_SUB_AB: begin opx = a; opy = ~b; end
      default:   begin opx = a; opy = b;  end
    endcase
  end

  assign arith = (op == OP_SUB_BA) || (op == OP_SUB_AB) || (op == OP_ADD);

  assign {c_msb, low_sum} = {1'b0, opx[MSB-1:0]} + {1'b0, opy[MSB-1:0]} + {{MSB{1'b0}}, cin};
  assign top_sum = {1'b0, opx[MSB]} + {1'b0, opy[MSB]} + {1'b0, c_msb};

  always_comb begin
    unique case (op_e'(op))
      OP_ZERO:  f = '0;
      OP_XOR:   f = a ^ b;
      OP_OR:    f = a | b;
      OP_AND:   f = a & b;
      OP_ONES:  f = '1;
      default:  f = {top_sum[0], low_sum};
    endcase
  end

  assign cout = arith & top_sum[1];
  assign ovf  = arith & (top_sum[1] ^ c_msb);

  logic [WIDTH:0] chk_add, chk_ab, chk_ba;
  assign chk_add = {1'b0, a} + {1'b0, b}  + {{WIDTH{1'b0}}, cin};
  assign chk_ab  = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, cin};
  assign chk_ba  = {1'b0, b} + {1'b0, ~a} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    AST_ZERO_CODE: assert (op != 3'b000 || (f == '0 && !cout && !ovf)); // R1
    AST_ONES_CODE: assert (op != 3'b111 || (f == '1 && !cout && !ovf)); // R2
    AST_ADD_SUM: assert (op != 3'b011 || {cout, f} == chk_add); // R3
    AST_SUB_AB_SUM: assert (op != 3'b010 || {cout, f} == chk_ab); // R4
    AST_SUB_BA_SUM: assert (op != 3'b001 || {cout, f} == chk_ba); // R5
    AST_LOGIC_QUIET: assert (arith || (!cout && !ovf)); // R7
    AST_OVF_SIGNED: assert (!arith || ovf == ((opx[MSB] == opy[MSB]) && (f[MSB] != opx[MSB]))); // R8
  end
endmodule

// File: rtl/alu_ripple_word.sv
module alu_ripple_word #(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 4
) (
  input  logic [SLICES*SLICE_W-1:0] a,
  input  logic [SLICES*SLICE_W-1:0] b,
  input  logic [2:0]                op,
  input  logic                      cin,
  output logic [SLICES*SLICE_W-1:0] f,
  output logic                      cout,
  output logic                      ovf
);
  localparam int W = SLICES * SLICE_W;

  logic [SLICES:0]   carry;
  logic [SLICES-1:0] slice_ovf;

  assign carry[0] = cin;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    alu_slice #(.WIDTH(SLICE_W)) slice_u (
      .a    (a[i*SLICE_W +: SLICE_W]),
      .b    (b[i*SLICE_W +: SLICE_W]),
      .op   (op),
      .cin  (carry[i]),
      .f    (f[i*SLICE_W +: SLICE_W]),
      .cout (carry[i+1]),
      .ovf  (slice_ovf[i])
    );
  end

  assign cout = carry[SLICES];
  assign ovf  = slice_ovf[SLICES-1];

  logic [W:0] word_add, word_ab;
  assign word_add = {1'b0, a} + {1'b0, b}  + {{W{1'b0}}, cin};
  assign word_ab  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};

  always_comb begin
    AST_WORD_ADD: assert (op != 3'b011 || {cout, f} == word_add); // R9
    AST_WORD_SUB: assert (op != 3'b010 || {cout, f} == word_ab); // R9
    AST_WORD_OVF: assert (op != 3'b011 || ovf == ((a[W-1] == b[W-1]) && (f[W-1] != a[W-1]))); // R9
  end
endmodule

// File: tb/alu_ripple_word_tb_top.sv
module alu_ripple_word_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a = '0, b = '0, f;
  logic [2:0]   op = '0;
  logic         cin = 1'b0, cout, ovf;

  logic [3:0] sa = '0, sb = '0, sf;
  logic [2:0] sop = '0;
  logic       scin = 1'b0, scout, sovf;

  int vectors = 0;
  int errors = 0;

  alu_ripple_word dut_i (.a(a), .b(b), .op(op), .cin(cin), .f(f), .cout(cout), .ovf(ovf));
  alu_slice #(.WIDTH(4)) slice_i (.a(sa), .b(sb), .op(sop), .cin(scin), .f(sf), .cout(scout), .ovf(sovf));

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'b000: tag = "R1/R7";
      3'b111: tag = "R2/R7";
      3'b011: tag = "R3/R8";
      3'b010: tag = "R4/R8";
      3'b001: tag = "R5/R8";
      default: tag = "R6/R7";
    endcase
  endfunction

  // expected {result, carry, overflow} for width n (n <= 16), packed as bits [17:0]
  function automatic logic [17:0] model(input int n, input logic [15:0] x, input logic [15:0] y,
                                        input logic [2:0] o, input logic c);
    logic [15:0] mask, p, q, r;
    logic [16:0] s;
    logic co, ov;
    mask = 16'((32'h1 << n) - 1);
    co = 1'b0; ov = 1'b0;
    p = x & mask; q = y & mask;
    case (o)
      3'b000: r = '0;
      3'b111: r = mask;
      3'b100: r = p ^ q;
      3'b101: r = p | q;
      3'b110: r = p & q;
      default: begin
        if (o == 3'b010) q = ~q & mask;
        if (o == 3'b001) begin q = p; p = ~(y & mask) & mask; p = ~(x & mask) & mask; q = y & mask; end
        s = {1'b0, p} + {1'b0, q} + {16'b0, c};
        r = s[15:0] & mask;
        co = s[n];
        ov = (p[n-1] == q[n-1]) && (r[n-1] != p[n-1]);
      end
    endcase
    model = {r, co, ov};
  endfunction

  task automatic check(input string t, input logic [17:0] got, input logic [17:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got f=%h co=%b ov=%b expected f=%h co=%b ov=%b",
               t, got[17:2], got[1], got[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic word(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] o, input logic c);
    @(posedge clk);
    a = x; b = y; op = o; cin = c;
    @(negedge clk);
    check({"R9 ", tag(o)}, {f, cout, ovf}, model(W, x, y, o, c));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {f, cout, ovf}, 18'h0);
    rst_n = 1'b1;

    // exhaustive single slice
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            sa = 4'(x); sb = 4'(y); sop = 3'(o); scin = c[0];
            @(negedge clk);
            check(tag(3'(o)), {12'h0, sf, scout, sovf}, model(4, 16'(x), 16'(y), 3'(o), c[0]));
          end

    // directed word corners
    word(16'h7FFF, 16'h0001, 3'b011, 1'b0); // R8 positive overflow
    word(16'h8000, 16'h0001, 3'b010, 1'b1); // R4 negative overflow
    word(16'h0001, 16'h8000, 3'b001, 1'b1); // R5
    word(16'hFFFF, 16'h0000, 3'b011, 1'b1); // R3 full ripple
    word(16'h1234, 16'h1234, 3'b010, 1'b1); // R4 zero difference
    word(16'hA5A5, 16'h5A5A, 3'b100, 1'b1); // R6/R7 carry ignored
    word(16'hFFFF, 16'hFFFF, 3'b111, 1'b1); // R2
    word(16'hFFFF, 16'hFFFF, 3'b000, 1'b1); // R1

    // seeded random words
    void'($urandom(32'h5EED_0382));
    for (int i = 0; i < 3000; i++)
      word(16'($urandom), 16'($urandom), 3'($urandom), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule